// File: doc/BRIEF.md
# Self-Polling Wake-Up Power Sequencer

This block sequences the power states of a low-power radio receiver. It follows a power-down pin and three software control bits: oscillator on, wake-timer on and host-driven receive on. From these it drives the receiver enable, the oscillator enable and a single DATA output. DATA carries demodulated bits while the host owns the receiver. It acts as a wake-up interrupt line while the block polls on its own. The control bits are held inside the block, because the power-down pin and the status read both change them. The register file and the serial bus that feed the write strobe stay outside.

In self-polling mode the sequencer runs a listen window, then a sleep window, and repeats. The listen window lasts `6 + code` timebase ticks, with one tick equal to 0.08 ms. The sleep window lasts a whole number N of listen windows, where N is 1 to 128. If a preamble was found during a listen window, DATA drops at the start of the next sleep window. It drops again on every later cycle until the host reads the status. That read ends self-polling and returns DATA high.

The oscillator start-up is modelled as a tick count. Ticks arrive on a separate enable input, so the block runs from any fast clock.

Top module: `wake_pwr_seq`

## Requirements
- R1: State codes on `state_o` are: Off=0, Asleep=1, Idle=2, HostRx=3, Snooze=4, Listen=5. While `rst` or `pwr_off_i` is high, the next cycle shows state Off, `rx_en_o`=0, `xo_en_o`=0 and `data_o`=1, and all control bits are cleared. Control writes made in Off are ignored. Releasing `pwr_off_i` gives Asleep one cycle later, and the block stays in Asleep with the oscillator off.
- R2: A control write (`ctl_wr_i`=1 loads `ctl_xo_i`, `ctl_tmr_i` and `ctl_srx_i` together) that sets the oscillator bit in Asleep raises `xo_en_o` at that same edge. The block reaches Idle exactly `XO_TICKS` ticks later. Clearing the oscillator bit in Idle gives Asleep with `xo_en_o`=0 one cycle after the write.
- R3: In Idle with oscillator=1, wake-timer=0 and receive=1, the block enters HostRx one cycle after the write, with `rx_en_o`=1. Clearing the receive bit returns it to Idle one cycle after the write, with `rx_en_o`=0.
- R4: In HostRx, `data_o` equals `demod_bit_i` delayed by one clock.
- R5: Setting the wake-timer bit in Idle enters Listen one cycle after the write. Listen lasts exactly `6 + tdet_code_i` ticks, with `rx_en_o`=1 and `data_o`=1 throughout.
- R6: Snooze follows Listen and lasts exactly `(ratio_code_i + 1) × (6 + tdet_code_i)` ticks, with `rx_en_o`=0 and `xo_en_o`=1. Listen follows it.
- R7: If `pre_det_i` was high during a Listen window, `data_o` is 0 from the first Snooze cycle to the end of that Snooze. Otherwise it stays 1.
- R8: While the status is not read, `data_o` returns to 1 in the next Listen and falls to 0 again in the next Snooze.
- R9: `isr_rd_i` in Listen or Snooze gives Idle with `data_o`=1 at the next edge. It clears the preamble flag and the wake-timer bit, so polling does not restart.
- R10: `pre_det_i` has no effect outside Listen. A pulse during Snooze leaves `data_o` at 1.
- R11: While `tick_i` is low, the window counters hold their values and the state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_off_i | input | 1 | Power-down pin, high forces Off |
| ctl_wr_i | input | 1 | Write strobe for the three control bits |
| ctl_xo_i | input | 1 | Oscillator-enable bit value |
| ctl_tmr_i | input | 1 | Wake-timer-enable bit value |
| ctl_srx_i | input | 1 | Host-receive-enable bit value |
| tdet_code_i | input | TDET_W | Listen window code, length 6+code ticks |
| ratio_code_i | input | RATIO_W | Snooze ratio code, N = code+1 |
| tick_i | input | 1 | Timebase tick enable (0.08 ms) |
| pre_det_i | input | 1 | Preamble-detected pulse |
| isr_rd_i | input | 1 | Interrupt-status read strobe |
| demod_bit_i | input | 1 | Demodulated data bit |
| rx_en_o | output | 1 | Receiver enable |
| xo_en_o | output | 1 | Oscillator enable |
| data_o | output | 1 | DATA pin: data stream or active-low wake interrupt |
| state_o | output | 3 | Current power state code |

## Verification
The bench measures each Listen and Snooze window in cycles, over several code and ratio pairs and at both extreme codes. An off-by-one in the reload would show up as windows one tick long or short, and a wrong ratio compare as a Snooze of the wrong number of periods. It checks that DATA falls on the first Snooze cycle and not during Listen, and that the interrupt repeats while the status stays unread. A design that cleared its flag on entering Listen would fail the repeat check. A late preamble pulse during Snooze, a frozen tick, and control writes made while powered down are each checked to have no effect. A design that latched any of them would wake, advance or leave Asleep when it should not.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_IDLE  = 3'd2,
    ST_HOST  = 3'd3,
    ST_SNOOZE= 3'd4,
    ST_LISTEN= 3'd5
  } pstate_t;
endpackage

// File: rtl/wps_ctl_bits.sv
module wps_ctl_bits (
  input  logic clk,
  input  logic rst,
  input  logic pwr_off_i,
  input  logic wr_ok_i,
  input  logic wr_i,
  input  logic xo_i,
  input  logic tmr_i,
  input  logic srx_i,
  input  logic isr_rd_i,
  output logic xo_q,
  output logic tmr_q,
  output logic srx_q,
  output logic xo_d
);
  logic tmr_d, srx_d;

  always_comb begin
    xo_d  = xo_q;
    tmr_d = tmr_q;
    srx_d = srx_q;
    if (pwr_off_i) begin
      xo_d  = 1'b0;
      tmr_d = 1'b0;
      srx_d = 1'b0;
    end else begin
      if (wr_i && wr_ok_i) begin
        xo_d  = xo_i;
        tmr_d = tmr_i;
        srx_d = srx_i;
      end
      if (isr_rd_i) tmr_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xo_q  <= 1'b0;
      tmr_q <= 1'b0;
      srx_q <= 1'b0;
    end else begin
      xo_q  <= xo_d;
      tmr_q <= tmr_d;
      srx_q <= srx_d;
    end
  end
endmodule

// File: rtl/wps_settle.sv
module wps_settle #(
  parameter int TICKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int W = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [W-1:0] LAST = W'(TICKS - 1);
  logic [W-1:0] cnt;

  assign done_o = en_i && tick_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i || done_o) cnt <= '0;
    else if (tick_i)            cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/wps_period_timer.sv
module wps_period_timer #(
  parameter int CODE_W = 8,
  parameter int BASE   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              expire_o
);
  localparam int CNT_W = $clog2(BASE + (1 << CODE_W));
  logic [CNT_W-1:0] cnt;

  assign expire_o = run_i && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (load_i)               cnt <= CNT_W'(BASE) + CNT_W'(code_i);
    else if (run_i && cnt != '0)   cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/wps_ratio_count.sv
module wps_ratio_count #(
  parameter int RATIO_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active_i,
  input  logic               step_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               done_o
);
  logic [RATIO_W-1:0] cnt;

  assign done_o = active_i && step_i && (cnt == ratio_i);

  always_ff @(posedge clk) begin
    if (rst || !active_i) cnt <= '0;
    else if (step_i)      cnt <= cnt + RATIO_W'(1);
  end
endmodule

// File: rtl/wps_fsm.sv
module wps_fsm
  import wps_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pwr_off_i,
  input  logic    xo_q,
  input  logic    tmr_q,
  input  logic    srx_q,
  input  logic    settled_i,
  input  logic    isr_rd_i,
  input  logic    pre_det_i,
  input  logic    win_exp_i,
  input  logic    ratio_done_i,
  output pstate_t state_q,
  output pstate_t state_d,
  output logic    flag_d
);
  logic flag_q;

  always_comb begin
    state_d = state_q;
    if (pwr_off_i) state_d = ST_OFF;
    else begin
      case (state_q)
        ST_OFF:    state_d = ST_SLEEP;
        ST_SLEEP:  if (settled_i) state_d = ST_IDLE;
        ST_IDLE: begin
          if (!xo_q)                      state_d = ST_SLEEP;
          else if (tmr_q && !isr_rd_i)    state_d = ST_LISTEN;
          else if (srx_q && !tmr_q)       state_d = ST_HOST;
        end
        ST_HOST:   if (!srx_q) state_d = ST_IDLE;
        ST_LISTEN: begin
          if (isr_rd_i || !tmr_q) state_d = ST_IDLE;
          else if (win_exp_i)     state_d = ST_SNOOZE;
        end
        ST_SNOOZE: begin
          if (isr_rd_i || !tmr_q) state_d = ST_IDLE;
          else if (ratio_done_i)  state_d = ST_LISTEN;
        end
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (pwr_off_i || isr_rd_i)                   flag_d = 1'b0;
    else if (pre_det_i && state_q == ST_LISTEN)  flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end
endmodule

// File: rtl/wake_pwr_seq.sv
module wake_pwr_seq
  import wps_pkg::*;
#(
  parameter int TDET_W    = 8,
  parameter int RATIO_W   = 7,
  parameter int TDET_BASE = 6,
  parameter int XO_TICKS  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_off_i,
  input  logic               ctl_wr_i,
  input  logic               ctl_xo_i,
  input  logic               ctl_tmr_i,
  input  logic               ctl_srx_i,
  input  logic [TDET_W-1:0]  tdet_code_i,
  input  logic [RATIO_W-1:0] ratio_code_i,
  input  logic               tick_i,
  input  logic               pre_det_i,
  input  logic               isr_rd_i,
  input  logic               demod_bit_i,
  output logic               rx_en_o,
  output logic               xo_en_o,
  output logic               data_o,
  output logic [2:0]         state_o
);
  pstate_t state_q, state_d;
  logic xo_q, tmr_q, srx_q, xo_d, flag_d;
  logic settled, win_exp, ratio_done, polling, win_load;

  wps_ctl_bits u_bits (
    .clk(clk), .rst(rst), .pwr_off_i(pwr_off_i),
    .wr_ok_i(state_q != ST_OFF), .wr_i(ctl_wr_i),
    .xo_i(ctl_xo_i), .tmr_i(ctl_tmr_i), .srx_i(ctl_srx_i),
    .isr_rd_i(isr_rd_i),
    .xo_q(xo_q), .tmr_q(tmr_q), .srx_q(srx_q), .xo_d(xo_d)
  );

  wps_settle #(.TICKS(XO_TICKS)) u_settle (
    .clk(clk), .rst(rst),
    .en_i(state_q == ST_SLEEP && xo_q && !pwr_off_i),
    .tick_i(tick_i), .done_o(settled)
  );

  assign polling  = (state_q == ST_LISTEN) || (state_q == ST_SNOOZE);
  assign win_load = win_exp || (state_q == ST_IDLE && state_d == ST_LISTEN);

  wps_period_timer #(.CODE_W(TDET_W), .BASE(TDET_BASE)) u_win (
    .clk(clk), .rst(rst), .load_i(win_load),
    .run_i(tick_i && polling), .code_i(tdet_code_i), .expire_o(win_exp)
  );

  wps_ratio_count #(.RATIO_W(RATIO_W)) u_ratio (
    .clk(clk), .rst(rst), .active_i(state_q == ST_SNOOZE),
    .step_i(win_exp), .ratio_i(ratio_code_i), .done_o(ratio_done)
  );

  wps_fsm u_fsm (
    .clk(clk), .rst(rst), .pwr_off_i(pwr_off_i),
    .xo_q(xo_q), .tmr_q(tmr_q), .srx_q(srx_q),
    .settled_i(settled), .isr_rd_i(isr_rd_i), .pre_det_i(pre_det_i),
    .win_exp_i(win_exp), .ratio_done_i(ratio_done),
    .state_q(state_q), .state_d(state_d), .flag_d(flag_d)
  );

  // Outputs are registered from the next state so they change on the
  // same edge as the state code.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en_o <= 1'b0;
      xo_en_o <= 1'b0;
      data_o  <= 1'b1;
    end else begin
      rx_en_o <= (state_d == ST_HOST) || (state_d == ST_LISTEN);
      xo_en_o <= (state_d == ST_IDLE) || (state_d == ST_HOST) ||
                 (state_d == ST_LISTEN) || (state_d == ST_SNOOZE) ||
                 (state_d == ST_SLEEP && xo_d);
      case (state_d)
        ST_HOST:   data_o <= demod_bit_i;
        ST_SNOOZE: data_o <= !flag_d;
        default:   data_o <= 1'b1;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/wake_pwr_seq_chk.sv
module wake_pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_off_i,
  input logic       isr_rd_i,
  input logic       demod_bit_i,
  input logic       rx_en_o,
  input logic       xo_en_o,
  input logic       data_o,
  input logic [2:0] state_o
);
  p_shutdown_r1: assert property (@(posedge clk) disable iff (rst)
    pwr_off_i |=> (state_o == 3'd0 && !rx_en_o && !xo_en_o && data_o));

  p_xo_on_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o >= 3'd2) |-> xo_en_o);

  p_host_data_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3) |-> (data_o == $past(demod_bit_i)));

  p_listen_high_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd5) |-> (data_o && rx_en_o));

  p_snooze_after_listen_r6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd5));

  p_snooze_steady_r7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4 && $past(state_o) == 3'd4) |-> $stable(data_o));

  p_read_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (isr_rd_i && !pwr_off_i && (state_o == 3'd4 || state_o == 3'd5))
      |=> (state_o == 3'd2 && data_o));
endmodule

bind wake_pwr_seq wake_pwr_seq_chk u_chk (
  .clk(clk), .rst(rst), .pwr_off_i(pwr_off_i), .isr_rd_i(isr_rd_i),
  .demod_bit_i(demod_bit_i), .rx_en_o(rx_en_o), .xo_en_o(xo_en_o),
  .data_o(data_o), .state_o(state_o)
);

// File: tb/tb_wake_pwr_seq.sv
module tb_wake_pwr_seq;
  localparam int XO_T = 5;
  localparam int NV = 5;
  localparam logic [2:0] S_OFF = 3'd0, S_SLEEP = 3'd1, S_IDLE = 3'd2,
                         S_HOST = 3'd3, S_SNOOZE = 3'd4, S_LISTEN = 3'd5;
  // stimulus: code, ratio, preamble; expected: listen and snooze lengths
  localparam int V_CODE [NV] = '{0, 3, 1, 0, 255};
  localparam int V_RAT  [NV] = '{0, 2, 4, 1, 127};
  localparam int V_DET  [NV] = '{0, 0, 1, 1, 0};
  localparam int V_LST  [NV] = '{6, 9, 7, 6, 261};
  localparam int V_SNZ  [NV] = '{6, 27, 35, 12, 33408};

  logic clk = 0, rst = 1, pwr_off_i = 1, ctl_wr_i = 0;
  logic ctl_xo_i = 0, ctl_tmr_i = 0, ctl_srx_i = 0;
  logic [7:0] tdet_code_i = 0;
  logic [6:0] ratio_code_i = 0;
  logic tick_i = 1, pre_det_i = 0, isr_rd_i = 0, demod_bit_i = 0;
  logic rx_en_o, xo_en_o, data_o;
  logic [2:0] state_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  wake_pwr_seq #(.XO_TICKS(XO_T)) dut (
    .clk(clk), .rst(rst), .pwr_off_i(pwr_off_i), .ctl_wr_i(ctl_wr_i),
    .ctl_xo_i(ctl_xo_i), .ctl_tmr_i(ctl_tmr_i), .ctl_srx_i(ctl_srx_i),
    .tdet_code_i(tdet_code_i), .ratio_code_i(ratio_code_i),
    .tick_i(tick_i), .pre_det_i(pre_det_i), .isr_rd_i(isr_rd_i),
    .demod_bit_i(demod_bit_i), .rx_en_o(rx_en_o), .xo_en_o(xo_en_o),
    .data_o(data_o), .state_o(state_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic xo, input logic tmr, input logic srx);
    ctl_wr_i = 1; ctl_xo_i = xo; ctl_tmr_i = tmr; ctl_srx_i = srx;
    step(1);
    ctl_wr_i = 0;
  endtask

  task automatic listen_len(input bit pulse, output int n, output int bad);
    n = 0; bad = 0;
    while (state_o == S_LISTEN && n < 40000) begin
      n++;
      if (data_o !== 1'b1 || rx_en_o !== 1'b1) bad++;
      pre_det_i = pulse && (n == 1);
      step(1);
    end
    pre_det_i = 0;
  endtask

  task automatic snooze_len(input bit det, output int n, output int bad);
    n = 0; bad = 0;
    while (state_o == S_SNOOZE && n < 40000) begin
      n++;
      if (data_o !== !det || rx_en_o !== 1'b0 || xo_en_o !== 1'b1) bad++;
      pre_det_i = !det && (n == 1);  // late pulse must be ignored (R10)
      step(1);
    end
    pre_det_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, bad;
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    chk(state_o == S_OFF && !rx_en_o && !xo_en_o && data_o, "R1 reset", state_o, S_OFF);
    pwr_off_i = 0;
    step(1);
    chk(state_o == S_SLEEP, "R1 release to asleep", state_o, S_SLEEP);

    // R2 oscillator start and settle
    wr(1, 0, 0);
    chk(xo_en_o == 1'b1, "R2 xo_en at write", xo_en_o, 1);
    n = 0;
    while (state_o != S_IDLE && n < 100) begin step(1); n++; end
    chk(n == XO_T, "R2 settle ticks", n, XO_T);

    // R3 host receive entry, R4 passthrough
    wr(1, 0, 1);
    step(1);
    chk(state_o == S_HOST && rx_en_o, "R3 enter host rx", state_o, S_HOST);
    demod_bit_i = 1; step(1);
    chk(data_o == 1'b1, "R4 passthrough one", data_o, 1);
    demod_bit_i = 0; step(1);
    chk(data_o == 1'b0, "R4 passthrough zero", data_o, 0);
    demod_bit_i = 1; step(1);
    chk(data_o == 1'b1, "R4 passthrough one again", data_o, 1);
    wr(1, 0, 0);
    step(1);
    chk(state_o == S_IDLE && !rx_en_o, "R3 leave host rx", state_o, S_IDLE);

    // R2 oscillator off then on again
    wr(0, 0, 0);
    step(1);
    chk(state_o == S_SLEEP && !xo_en_o, "R2 idle to asleep", state_o, S_SLEEP);
    wr(1, 0, 0);
    n = 0;
    while (state_o != S_IDLE && n < 100) begin step(1); n++; end
    chk(n == XO_T, "R2 settle again", n, XO_T);

    // vector table: self-polling windows
    for (int v = 0; v < NV; v++) begin
      tdet_code_i = 8'(V_CODE[v]);
      ratio_code_i = 7'(V_RAT[v]);
      wr(1, 1, 0);
      step(1);
      chk(state_o == S_LISTEN, "R5 enter listen", state_o, S_LISTEN);
      listen_len(V_DET[v] != 0, n, bad);
      chk(n == V_LST[v], "R5 listen length", n, V_LST[v]);
      chk(bad == 0, "R5 listen outputs", bad, 0);
      chk(state_o == S_SNOOZE && data_o == (V_DET[v] == 0), "R7 data at snooze entry",
          data_o, V_DET[v] == 0);
      snooze_len(V_DET[v] != 0, n, bad);
      chk(n == V_SNZ[v], "R6 snooze length", n, V_SNZ[v]);
      chk(bad == 0, "R7 R10 snooze data", bad, 0);
      chk(state_o == S_LISTEN && data_o, "R8 back to listen high", state_o, S_LISTEN);
      if (V_DET[v] != 0) begin
        listen_len(1'b0, n, bad);
        chk(n == V_LST[v] && bad == 0, "R8 second listen", n, V_LST[v]);
        chk(state_o == S_SNOOZE && data_o == 1'b0, "R8 repeat interrupt", data_o, 0);
      end
      isr_rd_i = 1; step(1); isr_rd_i = 0;
      chk(state_o == S_IDLE && data_o, "R9 read exits", state_o, S_IDLE);
      step(V_LST[v] + 2);
      chk(state_o == S_IDLE, "R9 no restart", state_o, S_IDLE);
    end

    // R11 tick held low freezes the window
    tdet_code_i = 0; ratio_code_i = 0;
    tick_i = 0;
    wr(1, 1, 0);
    step(1);
    step(30);
    chk(state_o == S_LISTEN, "R11 frozen listen", state_o, S_LISTEN);
    tick_i = 1;
    listen_len(1'b0, n, bad);
    chk(n == 6, "R11 window resumes", n, 6);

    // R1 power-down from snooze, writes ignored while off
    pwr_off_i = 1; step(1);
    chk(state_o == S_OFF && !rx_en_o && !xo_en_o && data_o, "R1 forced off", state_o, S_OFF);
    wr(1, 1, 1);
    pwr_off_i = 0; step(1);
    chk(state_o == S_SLEEP, "R1 release after off", state_o, S_SLEEP);
    step(XO_T + 3);
    chk(state_o == S_SLEEP && !xo_en_o, "R1 bits cleared", state_o, S_SLEEP);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule